// File: doc/BRIEF.md
# Keypad Controller Interrupt Status and Error Unit

This unit keeps the pending-interrupt status and the sticky error flags of a keypad controller. It drives one active-low interrupt line to the host. Set strobes arrive from the command interpreter as error codes and from the key event queue as keypad events. Each PWM engine also raises a one-cycle done strobe. The host reads the status through the command path. That read returns the current value and clears it, but only after the controller has been configured. The configuration-write path clears every pending status bit.

A small two-state machine tracks configuration. It starts in `CFG_PENDING`, where the not-initialized status bit is forced on and a status read clears nothing. A configuration write takes it to `CFG_DONE` (transition "configure"). It stays in `CFG_DONE` until reset (transition "reset", back to `CFG_PENDING`). The error register only accumulates bits, and only reset clears it.

Status bit positions: bit 0 keypad event, bit 3 error, bit 4 not initialized, bit 5+n PWM channel n done (n = 0..2). Bits 1 and 2 are always 0.
Error bit positions: bit 0 bad parameter, bit 1 unknown command, bit 2 key overrun, bit 6 queue overflow. The mask of valid error bits is 0x47.

Top module: `kpd_irq_err_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the status reads 0x10, the error register reads 0x00 and the interrupt line is low.
- R2: A key event strobe sets status bit 0 at the next clock edge. A done strobe on PWM channel n sets status bit 5+n at the next clock edge.
- R3: An error strobe ORs its valid bits (mask 0x47) into the error register and sets status bit 3 at the next edge. Bits outside the mask are ignored, and a strobe with no valid bit sets nothing.
- R4: The interrupt output is low in exactly those cycles where the status value is non-zero.
- R5: In state `CFG_PENDING` (status bit 4 set), a status read clears no status bit.
- R6: In state `CFG_DONE`, a status read presents the current value in the strobe cycle and leaves the status at zero after the edge, apart from bits set in that same cycle.
- R7: A configuration write clears the whole status register, including bit 4, at the next edge. Bit 4 does not come back until reset.
- R8: Only reset clears error bits. Status reads and configuration writes leave the error register unchanged.
- R9: When a set strobe coincides with a clearing read or a configuration write, the newly set bit is present after the edge.
- R10: Status bits 1 and 2 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_evt_i | input | 1 | Keypad event strobe from the event queue |
| pwm_done_i | input | 3 | Per-channel PWM done strobes |
| err_set_i | input | 8 | Error code bits to report (one cycle) |
| cfg_wr_i | input | 1 | Configuration write strobe |
| stat_rd_i | input | 1 | Status read strobe (clear on read) |
| stat_q_o | output | 8 | Current status value, also the read data |
| err_q_o | output | 8 | Current error register value |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
Every internal register reaches a port in the cycle after it changes. If the configuration state is wrong, status bit 4 and the interrupt line show it at the next edge. The same error also shows on the next read that should or should not clear. A lost set bit or a spurious clear shows on `stat_q_o` one edge after the strobe or read. A dropped or invented error bit shows on `err_q_o` one edge after the error strobe. The bench steps a behavioural model in lockstep with the unit and compares all three outputs every cycle, so any divergence is caught within one clock.

// File: rtl/kpd_irq_pkg.sv
package kpd_irq_pkg;
    localparam int STAT_W    = 8;
    localparam int ERR_W     = 8;
    localparam int NPWM_DEF  = 3;

    // status bit positions
    localparam int ST_KEY    = 0;
    localparam int ST_ERR    = 3;
    localparam int ST_UNINIT = 4;
    localparam int ST_PWM0   = 5;

    // error bit positions
    localparam int ER_BADPAR = 0;
    localparam int ER_UNKCMD = 1;
    localparam int ER_KEYOVR = 2;
    localparam int ER_QOVF   = 6;

    localparam logic [ERR_W-1:0] ERR_VALID =
        ERR_W'((1 << ER_BADPAR) | (1 << ER_UNKCMD) | (1 << ER_KEYOVR) | (1 << ER_QOVF));

    typedef enum logic [0:0] {
        CFG_PENDING = 1'b0,
        CFG_DONE    = 1'b1
    } cfg_state_e;
endpackage

// File: rtl/kpd_init_fsm.sv
module kpd_init_fsm
    import kpd_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr_i,
    output logic uninit_o,
    output logic clr_allow_o
);
    cfg_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_PENDING;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        uninit_o    = 1'b1;
        clr_allow_o = 1'b0;
        unique case (state_q)
            CFG_PENDING: begin
                uninit_o    = 1'b1;
                clr_allow_o = 1'b0;
                if (cfg_wr_i) state_d = CFG_DONE;
            end
            CFG_DONE: begin
                uninit_o    = 1'b0;
                clr_allow_o = 1'b1;
            end
            default: state_d = CFG_PENDING;
        endcase
    end
endmodule

// File: rtl/kpd_err_reg.sv
module kpd_err_reg
    import kpd_irq_pkg::*;
#(
    parameter int                 W     = ERR_W,
    parameter logic [ERR_W-1:0]   VALID = ERR_VALID
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] err_set_i,
    output logic [W-1:0] err_q_o,
    output logic         err_hit_o
);
    logic [W-1:0] req;
    assign req       = err_set_i & VALID[W-1:0];
    assign err_hit_o = |req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q_o <= '0;
        else        err_q_o <= err_q_o | req;
    end
endmodule

// File: rtl/kpd_stat_reg.sv
module kpd_stat_reg
    import kpd_irq_pkg::*;
#(
    parameter int W    = STAT_W,
    parameter int NPWM = NPWM_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            key_evt_i,
    input  logic [NPWM-1:0] pwm_done_i,
    input  logic            err_hit_i,
    input  logic            uninit_i,
    input  logic            clr_allow_i,
    input  logic            rd_i,
    input  logic            cfg_wr_i,
    output logic [W-1:0]    stat_o
);
    logic [W-1:0] set_vec;
    logic [W-1:0] pend_q;
    logic         clr;

    always_comb begin
        set_vec         = '0;
        set_vec[ST_KEY] = key_evt_i;
        set_vec[ST_ERR] = err_hit_i;
        for (int i = 0; i < NPWM; i++) begin
            set_vec[ST_PWM0 + i] = pwm_done_i[i];
        end
    end

    assign clr = cfg_wr_i | (rd_i & clr_allow_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pend_q <= '0;
        else if (clr) pend_q <= set_vec;
        else          pend_q <= pend_q | set_vec;
    end

    always_comb begin
        stat_o            = pend_q;
        stat_o[ST_UNINIT] = uninit_i;
    end
endmodule

// File: rtl/kpd_irq_err_unit.sv
module kpd_irq_err_unit
    import kpd_irq_pkg::*;
#(
    parameter int NPWM = NPWM_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_evt_i,
    input  logic [NPWM-1:0]   pwm_done_i,
    input  logic [ERR_W-1:0]  err_set_i,
    input  logic              cfg_wr_i,
    input  logic              stat_rd_i,
    output logic [STAT_W-1:0] stat_q_o,
    output logic [ERR_W-1:0]  err_q_o,
    output logic              irq_n_o
);
    localparam int TOP_BIT = ST_PWM0 + NPWM;

    logic uninit;
    logic clr_allow;
    logic err_hit;

    generate
        if (TOP_BIT > STAT_W) begin : g_bad_npwm
            initial $error("too many PWM channels for status width");
        end
    endgenerate

    kpd_init_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr_i),
        .uninit_o    (uninit),
        .clr_allow_o (clr_allow)
    );

    kpd_err_reg #(.W(ERR_W), .VALID(ERR_VALID)) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_set_i (err_set_i),
        .err_q_o   (err_q_o),
        .err_hit_o (err_hit)
    );

    kpd_stat_reg #(.W(STAT_W), .NPWM(NPWM)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_evt_i   (key_evt_i),
        .pwm_done_i  (pwm_done_i),
        .err_hit_i   (err_hit),
        .uninit_i    (uninit),
        .clr_allow_i (clr_allow),
        .rd_i        (stat_rd_i),
        .cfg_wr_i    (cfg_wr_i),
        .stat_o      (stat_q_o)
    );

    assign irq_n_o = ~(|stat_q_o);
endmodule

// File: rtl/kpd_irq_err_chk.sv
module kpd_irq_err_chk
    import kpd_irq_pkg::*;
#(
    parameter int NPWM = NPWM_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_evt_i,
    input logic [NPWM-1:0]   pwm_done_i,
    input logic [ERR_W-1:0]  err_set_i,
    input logic              cfg_wr_i,
    input logic              stat_rd_i,
    input logic [STAT_W-1:0] stat_q_o,
    input logic [ERR_W-1:0]  err_q_o,
    input logic              irq_n_o
);
    p_reset_val_r1: assert property (@(posedge clk)
        !rst_n |=> (stat_q_o == 8'h10) && (err_q_o == '0) && !irq_n_o);

    p_key_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        key_evt_i |=> stat_q_o[ST_KEY]);

    p_err_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(err_set_i & ERR_VALID)) |=> stat_q_o[ST_ERR] &&
            ((err_q_o & $past(err_set_i & ERR_VALID)) == $past(err_set_i & ERR_VALID)));

    p_irq_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        key_evt_i |=> !irq_n_o);

    p_uninit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q_o[ST_UNINIT] && !cfg_wr_i) |=> $stable(stat_q_o) || ($past(stat_q_o) & ~stat_q_o) == '0);

    p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !stat_q_o[ST_UNINIT] && !key_evt_i && (pwm_done_i == '0) &&
         ((err_set_i & ERR_VALID) == '0)) |=> (stat_q_o == '0));

    p_cfg_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_i |=> !stat_q_o[ST_UNINIT]);

    p_uninit_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_q_o[ST_UNINIT] |=> !stat_q_o[ST_UNINIT]);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(err_q_o) & ~err_q_o) == '0));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (key_evt_i && (stat_rd_i || cfg_wr_i)) |=> stat_q_o[ST_KEY]);

    p_dead_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q_o[2:1] == 2'b00);
endmodule

bind kpd_irq_err_unit kpd_irq_err_chk #(.NPWM(NPWM)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_evt_i  (key_evt_i),
    .pwm_done_i (pwm_done_i),
    .err_set_i  (err_set_i),
    .cfg_wr_i   (cfg_wr_i),
    .stat_rd_i  (stat_rd_i),
    .stat_q_o   (stat_q_o),
    .err_q_o    (err_q_o),
    .irq_n_o    (irq_n_o)
);

// File: tb/kpd_irq_err_unit_bench.sv
`timescale 1ns/1ps
module kpd_irq_err_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_evt_i = 1'b0;
    logic [2:0] pwm_done_i = '0;
    logic [7:0] err_set_i = '0;
    logic       cfg_wr_i = 1'b0;
    logic       stat_rd_i = 1'b0;
    logic [7:0] stat_q_o;
    logic [7:0] err_q_o;
    logic       irq_n_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    string cur_req = "R1";

    // reference model state
    int m_pend   = 0;
    int m_uninit = 1;
    int m_err    = 0;

    always #4 clk = ~clk;

    kpd_irq_err_unit u_kpd_irq_err_unit (
        .clk(clk), .rst_n(rst_n), .key_evt_i(key_evt_i), .pwm_done_i(pwm_done_i),
        .err_set_i(err_set_i), .cfg_wr_i(cfg_wr_i), .stat_rd_i(stat_rd_i),
        .stat_q_o(stat_q_o), .err_q_o(err_q_o), .irq_n_o(irq_n_o)
    );

    function automatic int exp_stat();
        return m_pend | (m_uninit << 4);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = 0; m_uninit = 1; m_err = 0;
        end else begin
            int ev;
            int setv;
            ev   = err_set_i & 8'h47;
            setv = (key_evt_i ? 1 : 0) | (ev != 0 ? 8 : 0) | (int'(pwm_done_i) << 5);
            if (cfg_wr_i) begin
                m_pend = setv; m_uninit = 0;
            end else if (stat_rd_i && m_uninit == 0) begin
                m_pend = setv;
            end else begin
                m_pend = m_pend | setv;
            end
            m_err = m_err | ev;
        end
    end

    // lockstep compare, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check({cur_req, " status"}, stat_q_o, exp_stat());
            check({cur_req, " error"},  err_q_o,  m_err);
            check("R4 irq", irq_n_o, (exp_stat() == 0) ? 1 : 0);
        end
    end

    task automatic cyc(input logic k, input logic [2:0] p, input logic [7:0] e,
                       input logic c, input logic r);
        key_evt_i = k; pwm_done_i = p; err_set_i = e; cfg_wr_i = c; stat_rd_i = r;
        @(posedge clk); #1;
        key_evt_i = 0; pwm_done_i = 0; err_set_i = 0; cfg_wr_i = 0; stat_rd_i = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset status", stat_q_o, 8'h10);
        check("R1 reset error", err_q_o, 0);
        check("R1 reset irq", irq_n_o, 0);
        rst_n = 1;
        @(posedge clk); #1;
        check("R1 after release", stat_q_o, 8'h10);

        cur_req = "R5";
        cyc(0, 0, 0, 0, 1);
        check("R5 read while unconfigured", stat_q_o, 8'h10);
        cur_req = "R2";
        cyc(1, 0, 0, 0, 0);
        check("R2 key sets bit0", stat_q_o, 8'h11);
        cur_req = "R5";
        cyc(0, 0, 0, 0, 1);
        check("R5 read keeps bits", stat_q_o, 8'h11);

        cur_req = "R3";
        cyc(0, 0, 8'hFF, 0, 0);
        check("R3 error masked", err_q_o, 8'h47);
        check("R3 error status bit", stat_q_o, 8'h19);
        check("R10 bits 1,2 zero", stat_q_o & 8'h06, 0);

        cur_req = "R7";
        cyc(0, 0, 0, 1, 0);
        check("R7 config clears", stat_q_o, 0);
        check("R4 irq released", irq_n_o, 1);
        check("R8 config keeps error", err_q_o, 8'h47);

        cur_req = "R2";
        for (int n = 0; n < 3; n++) begin
            cyc(0, 3'(1 << n), 0, 0, 0);
            check("R2 pwm done bit", stat_q_o[5+n], 1);
        end
        check("R2 pwm all", stat_q_o, 8'hE0);

        cur_req = "R6";
        stat_rd_i = 1; #1;
        check("R6 read data", stat_q_o, 8'hE0);
        @(posedge clk); #1; stat_rd_i = 0;
        check("R6 cleared", stat_q_o, 0);
        check("R8 read keeps error", err_q_o, 8'h47);

        cur_req = "R9";
        cyc(0, 3'b010, 0, 0, 0);
        cyc(1, 0, 0, 0, 1);
        check("R9 read vs key", stat_q_o, 8'h01);
        cyc(0, 3'b001, 0, 1, 0);
        check("R9 config vs pwm", stat_q_o, 8'h20);
        cyc(0, 0, 0, 0, 1);

        cur_req = "R3";
        cyc(0, 0, 8'h88, 0, 0);
        check("R3 invalid bits ignored", stat_q_o, 0);
        check("R3 invalid error unchanged", err_q_o, 8'h47);
        cur_req = "R7";
        check("R7 no uninit return", stat_q_o[4], 0);

        cur_req = "R1";
        rst_n = 0; #2;
        check("R1 async reset status", stat_q_o, 8'h10);
        check("R8 reset clears error", err_q_o, 0);
        @(posedge clk); #1; rst_n = 1;

        cur_req = "R9";
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0] & lfsr[3], lfsr[6:4] & {3{lfsr[7]}},
                (lfsr[9:8] == 2'b11) ? lfsr[15:8] : 8'h00,
                (lfsr[12:10] == 3'b000), lfsr[1] | lfsr[2]);
            if (i == 200) begin
                rst_n = 0; @(posedge clk); #1; rst_n = 1;
            end
        end

        @(negedge clk); #1;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule